// File: doc/BRIEF.md
# Cache Request Dispatcher

The block is the front end of a memory-side cache slice. Requests enter through one push port and are placed in a read queue or in a separate write queue. A single holding register takes one request at a time and resolves it through an external hit/miss lookup port. A read hit becomes a reply on the reply port. A write hit is retired with no further traffic. A miss is registered with an external miss-merge unit. When the miss is not merged with an outstanding one, it goes into an internal miss queue. Writes that miss do not allocate a line, and their size is trimmed before they are forwarded.

A second stage drains toward the DRAM scheduler. Pending writebacks always go before queued misses. The stage stops issuing while the scheduler reports full, but only when a scheduler queue is configured. Two mode inputs alter the routing. One is a read-priority mode that gives writes their own queue. The other is an ideal-cache mode that makes every lookup a hit. Four event counters report read hits, write hits, read misses and write misses.

Top module: `cdisp_top`

## Requirements
- R1: When the holding register is free, or frees in the current cycle, the next request comes from the read queue, and from the write queue only when the read queue is empty.
- R2: With `cfg_rd_prio` high, pushed writes go to the write queue. With it low, every request uses the read queue and requests resolve in push order. `in_ready` reflects the queue the push would enter.
- R3: A held read that hits is presented on `rep_valid`/`rep_addr` only while `rep_ready` is high. While `rep_ready` is low, the request stays held with `lk_addr` unchanged, and `cnt_rd_hit` does not move.
- R4: A held write that hits retires in one cycle. It produces no reply, no `mm_valid` and no memory request, and it adds one to `cnt_wr_hit`.
- R5: A held miss that finds the miss queue full stays held. `mm_valid` stays low for it and no counter moves. It is registered once space appears.
- R6: A registered miss with `mm_merged` high is dropped. One with `mm_merged` low enters the miss queue. A read miss keeps its byte count. A write miss (`dr_write` = 1) carries `in_bytes - RD_PKT_BYTES` (default 8).
- R7: When `wb_valid` is high and the scheduler is open, the writeback issues (`dr_wb` = 1, `dr_write` = 1) ahead of any queued miss.
- R8: While `cfg_sched_en` and `sched_full` are both high, `dr_valid` stays low. With `cfg_sched_en` low, `sched_full` has no effect.
- R9: With `cfg_ideal` high, every held request is treated as a hit, whatever `lk_hit` reports.
- R10: `cnt_rd_miss` and `cnt_wr_miss` each add one only in the cycle a queued miss of that kind issues on `dr_valid`. Writebacks and merged misses are not counted. Hit counters move only when the request retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_prio | input | 1 | Steer writes into the separate write queue |
| cfg_ideal | input | 1 | Treat every lookup as a hit |
| cfg_sched_en | input | 1 | Scheduler queue configured; enables `sched_full` |
| in_valid | input | 1 | Request push |
| in_ready | output | 1 | Target input queue has room |
| in_write | input | 1 | Request is a write |
| in_addr | input | ADDR_W | Request address |
| in_bytes | input | BYTE_W | Upstream byte count |
| lk_valid | output | 1 | Held request presented to lookup |
| lk_write | output | 1 | Held request is a write |
| lk_addr | output | ADDR_W | Held request address |
| lk_hit | input | 1 | Lookup result, same cycle |
| mm_valid | output | 1 | Register miss with merge unit |
| mm_addr | output | ADDR_W | Address of registered miss |
| mm_merged | input | 1 | Miss merged with an outstanding one |
| rep_valid | output | 1 | Reply pushed |
| rep_ready | input | 1 | Reply queue not full |
| rep_addr | output | ADDR_W | Reply address |
| wb_valid | input | 1 | Writeback pending |
| wb_ready | output | 1 | Writeback taken when valid |
| wb_addr | input | ADDR_W | Writeback address |
| wb_bytes | input | BYTE_W | Writeback byte count |
| dr_valid | output | 1 | Request issued to DRAM scheduler |
| dr_write | output | 1 | Issued request is a write |
| dr_wb | output | 1 | Issued request is a writeback |
| dr_addr | output | ADDR_W | Issued address |
| dr_bytes | output | BYTE_W | Issued byte count |
| sched_full | input | 1 | DRAM scheduler full |
| cnt_rd_hit | output | CNT_W | Read hits retired |
| cnt_rd_miss | output | CNT_W | Read misses issued |
| cnt_wr_hit | output | CNT_W | Write hits retired |
| cnt_wr_miss | output | CNT_W | Write misses issued |

## Verification
The bench targets ordering first. A stalled read hit is held while a write and then a read queue up behind it. In read-priority mode the read must issue first. Without that mode the two must issue in push order. A design that arbitrates wrongly shows the two memory requests swapped. The bench also fills the miss queue behind a full scheduler. A design that registers the overflowing miss early would show an extra `mm_valid`. One that ignores the configure bit would issue while blocked, or stay blocked after the bit drops. Further cases cover a writeback racing a queued miss, ideal mode on a missing address, and trimmed write-miss sizes. Wrong behaviour there appears as a reversed issue order, a missing reply or an untrimmed byte count.

// File: rtl/cdisp_pkg.sv
package cdisp_pkg;
  localparam int NUM_CNT    = 4;
  localparam int CI_RD_HIT  = 0;
  localparam int CI_RD_MISS = 1;
  localparam int CI_WR_HIT  = 2;
  localparam int CI_WR_MISS = 3;
endpackage

// File: rtl/cdisp_fifo.sv
module cdisp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/cdisp_front.sv
module cdisp_front #(
  parameter int ADDR_W       = 16,
  parameter int BYTE_W       = 8,
  parameter int RD_PKT_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_ideal,
  input  logic                       rdq_empty,
  input  logic [ADDR_W+BYTE_W:0]     rdq_head,
  input  logic                       wrq_empty,
  input  logic [ADDR_W+BYTE_W:0]     wrq_head,
  output logic                       rdq_pop,
  output logic                       wrq_pop,
  output logic                       lk_valid,
  output logic                       lk_write,
  output logic [ADDR_W-1:0]          lk_addr,
  input  logic                       lk_hit,
  output logic                       mm_valid,
  input  logic                       mm_merged,
  output logic                       rep_valid,
  input  logic                       rep_ready,
  input  logic                       missq_full,
  output logic                       missq_push,
  output logic [ADDR_W+BYTE_W:0]     missq_din,
  output logic                       rd_hit_inc,
  output logic                       wr_hit_inc
);
  localparam int REQ_W = 1 + ADDR_W + BYTE_W;

  logic             hold_vld_q, hold_vld_d;
  logic [REQ_W-1:0] hold_q, hold_d;
  logic             hold_en;
  logic             h_wr, hit, retire, take;
  logic [BYTE_W-1:0] h_bytes, fwd_bytes;

  assign h_wr    = hold_q[REQ_W-1];
  assign h_bytes = hold_q[BYTE_W-1:0];
  assign hit     = lk_hit | cfg_ideal;

  always_comb begin
    retire = 1'b0;
    if (hold_vld_q) begin
      if (hit) retire = h_wr ? 1'b1 : rep_ready;
      else     retire = !missq_full;
    end
    take    = !hold_vld_q || retire;
    rdq_pop = take && !rdq_empty;
    wrq_pop = take && rdq_empty && !wrq_empty;
    hold_vld_d = (hold_vld_q && !retire) || rdq_pop || wrq_pop;
    hold_en    = rdq_pop || wrq_pop;
    hold_d     = rdq_pop ? rdq_head : wrq_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      hold_vld_q <= hold_vld_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign fwd_bytes  = h_wr ? h_bytes - BYTE_W'(RD_PKT_BYTES) : h_bytes;
  assign lk_valid   = hold_vld_q;
  assign lk_write   = h_wr;
  assign lk_addr    = hold_q[ADDR_W+BYTE_W-1:BYTE_W];
  assign rep_valid  = hold_vld_q && hit && !h_wr && rep_ready;
  assign mm_valid   = hold_vld_q && !hit && !missq_full;
  assign missq_push = mm_valid && !mm_merged;
  assign missq_din  = {h_wr, lk_addr, fwd_bytes};
  assign rd_hit_inc = rep_valid;
  assign wr_hit_inc = hold_vld_q && hit && h_wr;
endmodule

// File: rtl/cdisp_mem_arb.sv
module cdisp_mem_arb #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                   cfg_sched_en,
  input  logic                   sched_full,
  input  logic                   wb_valid,
  input  logic [ADDR_W-1:0]      wb_addr,
  input  logic [BYTE_W-1:0]      wb_bytes,
  output logic                   wb_ready,
  input  logic                   missq_empty,
  input  logic [ADDR_W+BYTE_W:0] missq_head,
  output logic                   missq_pop,
  output logic                   dr_valid,
  output logic                   dr_wb,
  output logic [ADDR_W+BYTE_W:0] dr_req,
  output logic                   rd_miss_inc,
  output logic                   wr_miss_inc
);
  localparam int REQ_W = 1 + ADDR_W + BYTE_W;

  logic open_q;
  logic wb_take;

  assign open_q    = !(cfg_sched_en && sched_full);
  assign wb_ready  = open_q;
  assign wb_take   = open_q && wb_valid;
  assign missq_pop = open_q && !wb_valid && !missq_empty;

  assign dr_valid    = wb_take || missq_pop;
  assign dr_wb       = wb_take;
  assign dr_req      = wb_take ? {1'b1, wb_addr, wb_bytes} : missq_head;
  assign rd_miss_inc = missq_pop && !missq_head[REQ_W-1];
  assign wr_miss_inc = missq_pop && missq_head[REQ_W-1];
endmodule

// File: rtl/cdisp_top.sv
module cdisp_top #(
  parameter int ADDR_W       = 16,
  parameter int BYTE_W       = 8,
  parameter int IQ_DEPTH     = 4,
  parameter int MQ_DEPTH     = 4,
  parameter int RD_PKT_BYTES = 8,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rd_prio,
  input  logic              cfg_ideal,
  input  logic              cfg_sched_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BYTE_W-1:0] in_bytes,
  output logic              lk_valid,
  output logic              lk_write,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  output logic              mm_valid,
  output logic [ADDR_W-1:0] mm_addr,
  input  logic              mm_merged,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [ADDR_W-1:0] rep_addr,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [BYTE_W-1:0] wb_bytes,
  output logic              dr_valid,
  output logic              dr_write,
  output logic              dr_wb,
  output logic [ADDR_W-1:0] dr_addr,
  output logic [BYTE_W-1:0] dr_bytes,
  input  logic              sched_full,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss
);
  import cdisp_pkg::*;
  localparam int REQ_W = 1 + ADDR_W + BYTE_W;

  logic             wr_sel;
  logic             rdq_push, wrq_push, rdq_pop, wrq_pop;
  logic             rdq_empty, rdq_full, wrq_empty, wrq_full;
  logic [REQ_W-1:0] in_req, rdq_head, wrq_head;
  logic             mq_push, mq_pop, mq_empty, mq_full;
  logic [REQ_W-1:0] mq_din, mq_head, dr_req;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  assign wr_sel   = cfg_rd_prio && in_write;
  assign in_ready = wr_sel ? !wrq_full : !rdq_full;
  assign rdq_push = in_valid && in_ready && !wr_sel;
  assign wrq_push = in_valid && in_ready && wr_sel;
  assign in_req   = {in_write, in_addr, in_bytes};

  cdisp_fifo #(.W(REQ_W), .DEPTH(IQ_DEPTH)) u_rdq (
    .clk, .rst_n, .push(rdq_push), .din(in_req), .pop(rdq_pop),
    .dout(rdq_head), .empty(rdq_empty), .full(rdq_full));

  cdisp_fifo #(.W(REQ_W), .DEPTH(IQ_DEPTH)) u_wrq (
    .clk, .rst_n, .push(wrq_push), .din(in_req), .pop(wrq_pop),
    .dout(wrq_head), .empty(wrq_empty), .full(wrq_full));

  cdisp_front #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .RD_PKT_BYTES(RD_PKT_BYTES)) u_front (
    .clk, .rst_n, .cfg_ideal,
    .rdq_empty, .rdq_head, .wrq_empty, .wrq_head, .rdq_pop, .wrq_pop,
    .lk_valid, .lk_write, .lk_addr, .lk_hit,
    .mm_valid, .mm_merged, .rep_valid, .rep_ready,
    .missq_full(mq_full), .missq_push(mq_push), .missq_din(mq_din),
    .rd_hit_inc(cnt_inc[CI_RD_HIT]), .wr_hit_inc(cnt_inc[CI_WR_HIT]));

  cdisp_fifo #(.W(REQ_W), .DEPTH(MQ_DEPTH)) u_missq (
    .clk, .rst_n, .push(mq_push), .din(mq_din), .pop(mq_pop),
    .dout(mq_head), .empty(mq_empty), .full(mq_full));

  cdisp_mem_arb #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_arb (
    .cfg_sched_en, .sched_full, .wb_valid, .wb_addr, .wb_bytes, .wb_ready,
    .missq_empty(mq_empty), .missq_head(mq_head), .missq_pop(mq_pop),
    .dr_valid, .dr_wb, .dr_req,
    .rd_miss_inc(cnt_inc[CI_RD_MISS]), .wr_miss_inc(cnt_inc[CI_WR_MISS]));

  assign mm_addr  = lk_addr;
  assign rep_addr = lk_addr;
  assign dr_write = dr_req[REQ_W-1];
  assign dr_addr  = dr_req[ADDR_W+BYTE_W-1:BYTE_W];
  assign dr_bytes = dr_req[BYTE_W-1:0];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q[g] <= '0;
      else if (cnt_inc[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign cnt_rd_hit  = cnt_q[CI_RD_HIT];
  assign cnt_rd_miss = cnt_q[CI_RD_MISS];
  assign cnt_wr_hit  = cnt_q[CI_WR_HIT];
  assign cnt_wr_miss = cnt_q[CI_WR_MISS];
endmodule

// File: rtl/cdisp_chk.sv
module cdisp_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ideal,
  input logic              cfg_sched_en,
  input logic              sched_full,
  input logic              lk_valid,
  input logic              lk_write,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              mm_valid,
  input logic              rep_valid,
  input logic              rep_ready,
  input logic              wb_valid,
  input logic              dr_valid,
  input logic              dr_wb,
  input logic              dr_write,
  input logic [CNT_W-1:0]  cnt_rd_hit,
  input logic [CNT_W-1:0]  cnt_rd_miss
);
  logic rd_stall;
  assign rd_stall = lk_valid && !lk_write && (lk_hit || cfg_ideal) && !rep_ready;

  AST_NO_REPLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_ready |-> !rep_valid) else $error("reply while full"); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |=> lk_valid && $stable(lk_addr)) else $error("stalled read lost"); // R3

  AST_WR_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_write && (lk_hit || cfg_ideal) |-> !mm_valid && !rep_valid) else $error("write hit leaked"); // R4

  AST_WB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && dr_valid |-> dr_wb && dr_write) else $error("writeback overtaken"); // R7

  AST_SCHED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sched_en && sched_full |-> !dr_valid) else $error("issue while blocked"); // R8

  AST_RD_HIT_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd_hit != $past(cnt_rd_hit)) |-> $past(rep_valid)) else $error("stray hit count"); // R10

  AST_RD_MISS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_wb && !dr_write |=> cnt_rd_miss == $past(cnt_rd_miss) + 1'b1) else $error("miss count"); // R10
endmodule

bind cdisp_top cdisp_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ideal(cfg_ideal), .cfg_sched_en(cfg_sched_en),
  .sched_full(sched_full), .lk_valid(lk_valid), .lk_write(lk_write), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .mm_valid(mm_valid), .rep_valid(rep_valid), .rep_ready(rep_ready),
  .wb_valid(wb_valid), .dr_valid(dr_valid), .dr_wb(dr_wb), .dr_write(dr_write),
  .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss));

// File: tb/test_cdisp_top.sv
module test_cdisp_top;
  localparam int AW = 16;
  localparam int BW = 8;
  localparam int MQ = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rd_prio = 1'b0, cfg_ideal = 1'b0, cfg_sched_en = 1'b0;
  logic in_valid = 1'b0, in_write = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [BW-1:0] in_bytes = '0;
  logic in_ready, lk_valid, lk_write, lk_hit, mm_valid, mm_merged;
  logic [AW-1:0] lk_addr, mm_addr, rep_addr, dr_addr;
  logic rep_valid, rep_ready = 1'b1;
  logic wb_valid = 1'b0, wb_ready;
  logic [AW-1:0] wb_addr = '0;
  logic [BW-1:0] wb_bytes = '0;
  logic dr_valid, dr_write, dr_wb, sched_full = 1'b0;
  logic [BW-1:0] dr_bytes;
  logic [CW-1:0] cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;

  // environment: address bit 7 = line present, bit 6 = miss already outstanding
  assign lk_hit    = lk_addr[7];
  assign mm_merged = mm_addr[6];

  always #4 clk = ~clk;

  cdisp_top #(.ADDR_W(AW), .BYTE_W(BW), .MQ_DEPTH(MQ), .CNT_W(CW)) i_cdisp_top (
    .clk, .rst_n, .cfg_rd_prio, .cfg_ideal, .cfg_sched_en,
    .in_valid, .in_ready, .in_write, .in_addr, .in_bytes,
    .lk_valid, .lk_write, .lk_addr, .lk_hit, .mm_valid, .mm_addr, .mm_merged,
    .rep_valid, .rep_ready, .rep_addr, .wb_valid, .wb_ready, .wb_addr, .wb_bytes,
    .dr_valid, .dr_write, .dr_wb, .dr_addr, .dr_bytes, .sched_full,
    .cnt_rd_hit, .cnt_rd_miss, .cnt_wr_hit, .cnt_wr_miss);

  // event log: kind 1 reply, 2 memory miss, 3 writeback, 4 merge-unit registration
  int        ev_n = 0;
  int        ev_kind [256];
  logic [AW-1:0] ev_addr [256];
  logic [BW-1:0] ev_bytes [256];
  logic      ev_wr [256];
  int        mm_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rep_valid) begin
        ev_kind[ev_n % 256] = 1; ev_addr[ev_n % 256] = rep_addr;
        ev_bytes[ev_n % 256] = '0; ev_wr[ev_n % 256] = 1'b0; ev_n = ev_n + 1;
      end
      if (dr_valid) begin
        ev_kind[ev_n % 256] = dr_wb ? 3 : 2; ev_addr[ev_n % 256] = dr_addr;
        ev_bytes[ev_n % 256] = dr_bytes; ev_wr[ev_n % 256] = dr_write; ev_n = ev_n + 1;
      end
      if (mm_valid) mm_n = mm_n + 1;
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic push(input logic wr, input logic [AW-1:0] a, input logic [BW-1:0] b);
    in_valid = 1'b1; in_write = wr; in_addr = a; in_bytes = b;
    #1;
    while (!in_ready) begin @(posedge clk); #3; end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  typedef struct packed {
    logic          wr;
    logic [15:0]   addr;
    logic [7:0]    nb;
    logic [1:0]    kind;   // 0 none, 1 reply, 2 memory request
    logic [7:0]    exp_nb;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 16'h0080, 8'd16, 2'd1, 8'd0},   // read hit           R3
    '{1'b0, 16'h0100, 8'd16, 2'd2, 8'd16},  // read miss          R6
    '{1'b1, 16'h0284, 8'd40, 2'd0, 8'd0},   // write hit          R4
    '{1'b1, 16'h0300, 8'd40, 2'd2, 8'd32},  // write miss trimmed R6
    '{1'b0, 16'h0440, 8'd16, 2'd0, 8'd0},   // merged read miss   R6
    '{1'b1, 16'h0540, 8'd40, 2'd0, 8'd0},   // merged write miss  R6
    '{1'b0, 16'h00C0, 8'd16, 2'd1, 8'd0},   // hit wins           R3
    '{1'b0, 16'h0700, 8'd24, 2'd2, 8'd24}   // read miss          R6
  };

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, c0, c1, c2, c3, m0;
    tick(3);
    #1;
    // reset state
    chk(cnt_rd_hit == 0 && cnt_wr_hit == 0, "R10 reset hit counters", int'(cnt_rd_hit) + int'(cnt_wr_hit), 0);
    chk(cnt_rd_miss == 0 && cnt_wr_miss == 0, "R10 reset miss counters", int'(cnt_rd_miss) + int'(cnt_wr_miss), 0);
    chk(!rep_valid && !dr_valid && !lk_valid, "R3 reset outputs idle", {rep_valid, dr_valid, lk_valid}, 0);
    rst_n = 1'b1;
    tick(1);
    chk(in_ready == 1'b1, "R2 in_ready after reset", in_ready, 1);

    // table walk, shared queue
    for (int v = 0; v < 8; v++) begin
      base = ev_n;
      push(TBL[v].wr, TBL[v].addr, TBL[v].nb);
      tick(5);
      chk(ev_n - base == (TBL[v].kind != 0 ? 1 : 0), $sformatf("R6 vector %0d event count", v),
          ev_n - base, (TBL[v].kind != 0 ? 1 : 0));
      if (TBL[v].kind != 0 && ev_n > base) begin
        chk(ev_kind[base] == int'(TBL[v].kind) && ev_addr[base] == TBL[v].addr,
            $sformatf("R3 vector %0d kind/addr", v), ev_addr[base], TBL[v].addr);
        if (TBL[v].kind == 2)
          chk(ev_bytes[base] == TBL[v].exp_nb && ev_wr[base] == TBL[v].wr,
              $sformatf("R6 vector %0d bytes", v), ev_bytes[base], TBL[v].exp_nb);
      end
    end
    chk(cnt_rd_hit == 2, "R10 read hits", cnt_rd_hit, 2);
    chk(cnt_wr_hit == 1, "R4 write hits", cnt_wr_hit, 1);
    chk(cnt_rd_miss == 2, "R10 read misses", cnt_rd_miss, 2);
    chk(cnt_wr_miss == 1, "R10 write misses", cnt_wr_miss, 1);

    // R1: read queue wins over write queue in read-priority mode
    cfg_rd_prio = 1'b1; rep_ready = 1'b0;
    base = ev_n; c0 = cnt_rd_hit;
    push(1'b0, 16'h0880, 8'd16);
    tick(3);
    chk(ev_n == base, "R3 no reply while full", ev_n - base, 0);
    chk(cnt_rd_hit == CW'(c0), "R3 stalled hit not counted", cnt_rd_hit, c0);
    chk(lk_valid && lk_addr == 16'h0880, "R3 stalled read held", lk_addr, 16'h0880);
    push(1'b1, 16'h0900, 8'd40);
    push(1'b0, 16'h0A00, 8'd16);
    rep_ready = 1'b1;
    tick(8);
    chk(ev_n - base == 3, "R1 event count", ev_n - base, 3);
    chk(ev_kind[base] == 1 && ev_addr[base] == 16'h0880, "R3 released reply", ev_addr[base], 16'h0880);
    chk(ev_addr[base+1] == 16'h0A00, "R1 read before write", ev_addr[base+1], 16'h0A00);
    chk(ev_addr[base+2] == 16'h0900 && ev_bytes[base+2] == 8'd32, "R1 write after read", ev_addr[base+2], 16'h0900);
    chk(cnt_rd_hit == CW'(c0 + 1), "R10 hit counted once", cnt_rd_hit, c0 + 1);

    // R2: shared queue keeps push order
    cfg_rd_prio = 1'b0; rep_ready = 1'b0;
    base = ev_n;
    push(1'b0, 16'h0B80, 8'd16);
    push(1'b1, 16'h0C00, 8'd40);
    push(1'b0, 16'h0D00, 8'd16);
    tick(2);
    rep_ready = 1'b1;
    tick(8);
    chk(ev_n - base == 3, "R2 event count", ev_n - base, 3);
    chk(ev_addr[base+1] == 16'h0C00, "R2 write keeps order", ev_addr[base+1], 16'h0C00);
    chk(ev_addr[base+2] == 16'h0D00, "R2 read after write", ev_addr[base+2], 16'h0D00);

    // R5/R8: miss queue full behind a blocked scheduler
    cfg_sched_en = 1'b1; sched_full = 1'b1;
    base = ev_n; m0 = mm_n; c1 = cnt_rd_miss;
    for (int i = 0; i <= MQ; i++) push(1'b0, AW'(16'h1000 + i * 16'h0100), 8'd16);
    tick(6);
    chk(ev_n == base, "R8 no issue while blocked", ev_n - base, 0);
    chk(mm_n - m0 == MQ, "R5 overflow miss not registered", mm_n - m0, MQ);
    chk(lk_valid && lk_addr == 16'h1400, "R5 overflow miss held", lk_addr, 16'h1400);
    chk(cnt_rd_miss == CW'(c1), "R5 nothing counted", cnt_rd_miss, c1);
    cfg_sched_en = 1'b0;
    tick(10);
    chk(ev_n - base == MQ + 1, "R8 full ignored when unconfigured", ev_n - base, MQ + 1);
    chk(ev_addr[base+MQ] == 16'h1400, "R5 held miss issues last", ev_addr[base+MQ], 16'h1400);
    chk(mm_n - m0 == MQ + 1, "R5 registered once", mm_n - m0, MQ + 1);
    chk(cnt_rd_miss == CW'(c1 + MQ + 1), "R10 issued misses counted", cnt_rd_miss, c1 + MQ + 1);

    // R7: writeback ahead of queued miss
    cfg_sched_en = 1'b1; sched_full = 1'b1;
    base = ev_n; c1 = cnt_rd_miss; c3 = cnt_wr_miss;
    push(1'b0, 16'h2000, 8'd16);
    tick(4);
    wb_valid = 1'b1; wb_addr = 16'h3000; wb_bytes = 8'd32;
    tick(1);
    sched_full = 1'b0;
    tick(1);
    wb_valid = 1'b0;
    tick(4);
    chk(ev_n - base == 2, "R7 event count", ev_n - base, 2);
    chk(ev_kind[base] == 3 && ev_addr[base] == 16'h3000, "R7 writeback first", ev_addr[base], 16'h3000);
    chk(ev_kind[base+1] == 2 && ev_addr[base+1] == 16'h2000, "R7 miss second", ev_addr[base+1], 16'h2000);
    chk(cnt_wr_miss == CW'(c3) && cnt_rd_miss == CW'(c1 + 1), "R10 writeback not counted", cnt_wr_miss, c3);
    cfg_sched_en = 1'b0;

    // R9: ideal mode
    cfg_ideal = 1'b1;
    base = ev_n; c2 = cnt_wr_hit; m0 = mm_n;
    push(1'b0, 16'h4000, 8'd16);
    push(1'b1, 16'h4100, 8'd40);
    tick(5);
    chk(ev_n - base == 1 && ev_kind[base] == 1 && ev_addr[base] == 16'h4000, "R9 miss address replies", ev_addr[base], 16'h4000);
    chk(cnt_wr_hit == CW'(c2 + 1) && mm_n == m0, "R9 write treated as hit", cnt_wr_hit, c2 + 1);
    cfg_ideal = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule